// File: doc/BRIEF.md
# Multi-Mode Analog Front End Serial Frame Port

This block is the digital side of an analog front end's serial link to a DSP. The port is always the master. Each sample strobe from the decimator starts one 16-bit frame. The port drives a one-clock frame-sync pulse, then shifts one bit per clock on the serial output, most significant bit first. In the same cycles it shifts the DSP's reply in from the serial input. A single 16-bit shift register carries both words: the outgoing word is loaded at the start of the frame, and once the frame completes the register holds the incoming word.

The port has a bank of eight 8-bit configuration registers. Bits [1:0] of register 0 select one of three modes:
- **Control mode:** incoming control frames write or read the bank.
- **Data mode:** every incoming frame is discarded, and the outgoing frames carry the 15-bit sample left-justified.
- **Mixed mode:** the most significant bit of a frame separates control frames from data frames, and samples are sent right-justified at 15 bits.

The controller has four states:
- `ST_IDLE` waits for a strobe (transition *start*).
- `ST_SYNC` asserts frame sync (transition *sync_done*).
- `ST_SHIFT` moves 16 bits (transition *last_bit*).
- `ST_APPLY` decodes the received word and returns to idle (transition *applied*).

Top module: `afe_serial_port`

## Requirements
- R1: After reset, all eight configuration registers read zero, which selects control mode. Frame sync and serial output are low.
- R2: A sample strobe seen in `ST_IDLE` produces a single-cycle frame-sync pulse on the next cycle. The 16 outgoing bits follow on the next 16 cycles, MSB first. The serial output is 0 outside those 16 cycles. Each incoming bit is sampled at the end of its bit cycle.
- R3: In data mode (register 0 bits [1:0] = 01), the outgoing word is the 15-bit two's complement sample shifted left one place, with bit 0 = 0.
- R4: In data mode, when the over-range input is high with the strobe, the outgoing word is 0x7FFF.
- R5: In data mode, incoming frames change no register and queue no read reply.
- R6: In a non-data mode, an incoming frame is a control word when bit 15 = 1. If bit 14 = 0, the frame writes bits [7:0] into the register addressed by bits [13:11]. The write takes effect in the cycle after the last bit. A frame with bit 15 = 0 is ignored.
- R7: A control word with bit 14 = 1 queues a read. The next frame sends {1, 1, addr[2:0], 000, data[7:0]}, where data is the register value when that frame starts.
- R8: In mixed mode (bits [1:0] = 11), a data frame is {0, sample[14:0]}. On over-range, the frame is 0x3FFF.
- R9: In mixed mode, incoming words with bit 15 = 1 are decoded as in R6 and R7. Words with bit 15 = 0 are ignored.
- R10: Register 0 bits [1:0] select the mode: bit 0 = 0 selects control mode whatever bit 1 is. In control mode with no queued read, the outgoing word is 0x0000.
- R11: A strobe that arrives while a frame is in progress is ignored. It produces no extra frame-sync pulse and does not disturb the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb_i | input | 1 | Output sample event from the decimator |
| sample_i | input | 15 | Two's complement ADC sample |
| sample_ovf_i | input | 1 | Sample at or above positive full scale |
| sdi_i | input | 1 | Serial data from the DSP |
| fs_o | output | 1 | Frame-sync pulse, one cycle before the MSB |
| sdo_o | output | 1 | Serial data to the DSP |
| cfg_o | output | 64 | Configuration registers; register n at bits [8n+7:8n] |

## Verification
The assertions check these properties on every cycle:
- Frame sync is never asserted in two consecutive cycles.
- The serial output is low while idle and during sync.
- Two sync pulses are never closer than one full frame.
- Configuration changes only in the cycle after `ST_APPLY`.
- Configuration never changes while data mode is selected.

Only the bench's scenarios can show the rest:
- the exact formatted word in each mode;
- saturation in both justifications;
- read replies landing in the following frame;
- correct decoding of addresses and data.

The bench's behavioural model predicts these frame by frame.

// File: rtl/afe_sport_pkg.sv
package afe_sport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_SHIFT,
        ST_APPLY
    } frame_state_e;

    typedef enum logic [1:0] {
        MD_CONTROL,
        MD_DATA,
        MD_MIXED
    } port_mode_e;

    function automatic port_mode_e decode_mode(input logic [1:0] sel);
        if (!sel[0])
            return MD_CONTROL;
        else if (sel[1])
            return MD_MIXED;
        else
            return MD_DATA;
    endfunction

endpackage

// File: rtl/afe_cfg_bank.sv
module afe_cfg_bank #(
    parameter int unsigned NREG   = 8,
    parameter int unsigned REG_W  = 8,
    parameter int unsigned ADDR_W = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [REG_W-1:0]        rd_data,
    output logic [NREG*REG_W-1:0]   cfg_flat
);

    logic [REG_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                regs[g] <= wr_data;
        end
        assign cfg_flat[g*REG_W +: REG_W] = regs[g];
    end

    assign rd_data = regs[rd_addr];

endmodule

// File: rtl/afe_sample_fmt.sv
module afe_sample_fmt
    import afe_sport_pkg::*;
#(
    parameter int unsigned FRAME_W  = 16,
    parameter int unsigned SAMPLE_W = 15,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned ADDR_W   = 3
) (
    input  port_mode_e          mode,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                ovf,
    input  logic                resp_valid,
    input  logic [ADDR_W-1:0]   resp_addr,
    input  logic [REG_W-1:0]    resp_data,
    output logic [FRAME_W-1:0]  word
);

    localparam int unsigned PAD = FRAME_W - SAMPLE_W;

    always_comb begin
        word = '0;
        if (resp_valid) begin
            word[FRAME_W-1]            = 1'b1;
            word[FRAME_W-2]            = 1'b1;
            word[FRAME_W-3 -: ADDR_W]  = resp_addr;
            word[REG_W-1:0]            = resp_data;
        end else begin
            unique case (mode)
                MD_DATA: begin
                    if (ovf)
                        word = {1'b0, {(FRAME_W-1){1'b1}}};
                    else
                        word = {sample, {PAD{1'b0}}};
                end
                MD_MIXED: begin
                    if (ovf)
                        word = {{PAD{1'b0}}, 1'b0, {(SAMPLE_W-1){1'b1}}};
                    else
                        word = {{PAD{1'b0}}, sample};
                end
                default: word = '0;
            endcase
        end
    end

endmodule

// File: rtl/afe_frame_ctrl.sv
module afe_frame_ctrl
    import afe_sport_pkg::*;
#(
    parameter int unsigned FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_stb,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               sdi,
    output logic               fs,
    output logic               sdo,
    output logic               load,
    output logic               apply,
    output logic [FRAME_W-1:0] rx_word,
    output frame_state_e       state
);

    localparam int unsigned CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    frame_state_e       state_q, state_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sample_stb) state_d = ST_SYNC;
            ST_SYNC:  state_d = ST_SHIFT;
            ST_SHIFT: if (bit_cnt == LAST_BIT) state_d = ST_APPLY;
            ST_APPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fs    = (state_q == ST_SYNC);
        sdo   = (state_q == ST_SHIFT) ? shreg[FRAME_W-1] : 1'b0;
        load  = (state_q == ST_IDLE) && sample_stb;
        apply = (state_q == ST_APPLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (state_q == ST_SHIFT)
            bit_cnt <= bit_cnt + 1'b1;
        else
            bit_cnt <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (load)
            shreg <= tx_word;
        else if (state_q == ST_SHIFT)
            shreg <= {shreg[FRAME_W-2:0], sdi};
    end

    assign rx_word = shreg;
    assign state   = state_q;

endmodule

// File: rtl/afe_serial_port.sv
module afe_serial_port
    import afe_sport_pkg::*;
#(
    parameter int unsigned FRAME_W  = 16,
    parameter int unsigned SAMPLE_W = FRAME_W - 1,
    parameter int unsigned NREG     = 8,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned MODE_REG = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_stb_i,
    input  logic [SAMPLE_W-1:0]   sample_i,
    input  logic                  sample_ovf_i,
    input  logic                  sdi_i,
    output logic                  fs_o,
    output logic                  sdo_o,
    output logic [NREG*REG_W-1:0] cfg_o
);

    localparam int unsigned ADDR_W = $clog2(NREG);
    localparam int unsigned ADDR_LSB = FRAME_W - 2 - ADDR_W;

    frame_state_e       frame_state;
    port_mode_e         mode;
    logic [FRAME_W-1:0] tx_word, rx_word;
    logic               load, apply;
    logic               pend_q;
    logic [ADDR_W-1:0]  pend_addr_q;
    logic [REG_W-1:0]   rd_data;
    logic               rx_ctl, rx_rd, accept, wr_en;
    logic [ADDR_W-1:0]  rx_addr;
    logic [REG_W-1:0]   rx_data;
    logic               rx_unused_bits;

    assign mode = decode_mode(cfg_o[MODE_REG*REG_W +: 2]);

    assign rx_ctl         = rx_word[FRAME_W-1];
    assign rx_rd          = rx_word[FRAME_W-2];
    assign rx_addr        = rx_word[FRAME_W-3 -: ADDR_W];
    assign rx_data        = rx_word[REG_W-1:0];
    assign rx_unused_bits = ^rx_word[ADDR_LSB-1:REG_W];

    assign accept = apply && (mode != MD_DATA) && rx_ctl;
    assign wr_en  = accept && !rx_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else if (load) begin
            pend_q      <= 1'b0;
        end else if (accept && rx_rd) begin
            pend_q      <= 1'b1;
            pend_addr_q <= rx_addr;
        end
    end

    afe_cfg_bank #(
        .NREG  (NREG),
        .REG_W (REG_W),
        .ADDR_W(ADDR_W)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (rx_addr),
        .wr_data (rx_data),
        .rd_addr (pend_addr_q),
        .rd_data (rd_data),
        .cfg_flat(cfg_o)
    );

    afe_sample_fmt #(
        .FRAME_W (FRAME_W),
        .SAMPLE_W(SAMPLE_W),
        .REG_W   (REG_W),
        .ADDR_W  (ADDR_W)
    ) i_fmt (
        .mode      (mode),
        .sample    (sample_i),
        .ovf       (sample_ovf_i),
        .resp_valid(pend_q && (mode != MD_DATA)),
        .resp_addr (pend_addr_q),
        .resp_data (rd_data),
        .word      (tx_word)
    );

    afe_frame_ctrl #(
        .FRAME_W(FRAME_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_stb(sample_stb_i),
        .tx_word   (tx_word),
        .sdi       (sdi_i),
        .fs        (fs_o),
        .sdo       (sdo_o),
        .load      (load),
        .apply     (apply),
        .rx_word   (rx_word),
        .state     (frame_state)
    );

endmodule

// File: rtl/afe_serial_port_chk.sv
module afe_serial_port_chk
    import afe_sport_pkg::*;
#(
    parameter int unsigned FRAME_W = 16,
    parameter int unsigned CFG_W   = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fs_o,
    input logic             sdo_o,
    input logic [CFG_W-1:0] cfg_o,
    input frame_state_e     state
);

    localparam int unsigned GAP_W = $clog2(FRAME_W + 8) + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;
    localparam logic [GAP_W-1:0] MIN_GAP = GAP_W'(FRAME_W + 1);

    logic [GAP_W-1:0] since_fs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_fs <= GAP_MAX;
        else if (fs_o)
            since_fs <= '0;
        else if (since_fs != GAP_MAX)
            since_fs <= since_fs + 1'b1;
    end

    a_r2_fs_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |=> !fs_o);

    a_r2_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_o || state == ST_IDLE) |-> !sdo_o);

    a_r11_fs_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |-> (since_fs > MIN_GAP));

    a_r6_write_after_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> ($past(state) == ST_APPLY));

    a_r5_data_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o[1:0] == 2'b01) |=> $stable(cfg_o));

endmodule

bind afe_serial_port afe_serial_port_chk #(
    .FRAME_W(FRAME_W),
    .CFG_W  (NREG*REG_W)
) i_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .fs_o (fs_o),
    .sdo_o(sdo_o),
    .cfg_o(cfg_o),
    .state(frame_state)
);

// File: tb/test_afe_serial_port.sv
module test_afe_serial_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb_i = 1'b0;
    logic [14:0] sample_i = '0;
    logic        sample_ovf_i = 1'b0;
    logic        sdi_i = 1'b0;
    logic        fs_o, sdo_o;
    logic [63:0] cfg_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int          regs [8];
    bit          pend = 0;
    int          paddr = 0;

    always #10 clk = ~clk;

    afe_serial_port i_afe_serial_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_stb_i(sample_stb_i),
        .sample_i    (sample_i),
        .sample_ovf_i(sample_ovf_i),
        .sdi_i       (sdi_i),
        .fs_o        (fs_o),
        .sdo_o       (sdo_o),
        .cfg_o       (cfg_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_cfg();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = regs[i][7:0];
        return v;
    endfunction

    task automatic run_frame(input logic [14:0] s, input logic ovf, input logic [15:0] rx,
                             input bit mid, input string tag);
        logic [15:0] exp_tx, got_tx;
        int          mode;
        bit          fs_ok;
        mode = regs[0] & 3;
        if (pend && mode != 1)
            exp_tx = {2'b11, 3'(paddr), 3'b000, 8'(regs[paddr])};
        else if (mode == 1)
            exp_tx = ovf ? 16'h7FFF : {s, 1'b0};
        else if (mode == 3)
            exp_tx = ovf ? 16'h3FFF : {1'b0, s};
        else
            exp_tx = 16'h0000;
        pend = 0;
        @(negedge clk);
        sample_stb_i = 1'b1; sample_i = s; sample_ovf_i = ovf;
        @(negedge clk);
        sample_stb_i = 1'b0;
        fs_ok = (fs_o === 1'b1) && (sdo_o === 1'b0);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (fs_o !== 1'b0) fs_ok = 0;
            got_tx[15-k] = sdo_o;
            sdi_i = rx[15-k];
            sample_stb_i = (mid && k == 5);
        end
        @(negedge clk);
        sdi_i = 1'b0;
        if (fs_o !== 1'b0 || sdo_o !== 1'b0) fs_ok = 0;
        @(negedge clk);
        if (fs_o !== 1'b0 || sdo_o !== 1'b0) fs_ok = 0;
        if (mode != 1 && rx[15]) begin
            if (rx[14]) begin
                pend = 1; paddr = int'(rx[13:11]);
            end else begin
                regs[rx[13:11]] = int'(rx[7:0]);
            end
        end
        check(fs_ok, mid ? "R11 sync/shape with mid-frame strobe" : "R2 frame sync and shape", {63'd0, fs_o}, 64'd1);
        check(got_tx === exp_tx, {tag, " outgoing word"}, {48'd0, got_tx}, {48'd0, exp_tx});
        check(cfg_o === model_cfg(), {tag, " configuration"}, cfg_o, model_cfg());
    endtask

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_o === 64'd0, "R1 registers cleared", cfg_o, 64'd0);
        check(fs_o === 1'b0 && sdo_o === 1'b0, "R1 outputs idle", {62'd0, fs_o, sdo_o}, 64'd0);
        // control mode
        run_frame(15'h1234, 1'b0, 16'h8002, 0, "R10 mode 10 stays control");
        run_frame(15'h0F0F, 1'b0, 16'h98A5, 0, "R6 write reg3");
        run_frame(15'h0F0F, 1'b0, 16'h3BCD, 0, "R6 msb0 ignored");
        run_frame(15'h0001, 1'b0, 16'hD800, 0, "R7 read request reg3");
        run_frame(15'h0002, 1'b0, 16'h8003, 0, "R7 reply then mixed");
        // mixed mode
        run_frame(15'h1234, 1'b0, 16'hA85A, 0, "R8 R9 mixed data and write");
        run_frame(15'h7000, 1'b1, 16'h2BCD, 0, "R8 R9 mixed saturate, msb0 ignored");
        run_frame(15'h0555, 1'b0, 16'hE800, 0, "R9 mixed read request");
        run_frame(15'h0666, 1'b0, 16'h8001, 0, "R7 R10 mixed reply then data");
        // data mode
        run_frame(15'h1234, 1'b0, 16'h98FF, 0, "R3 R5 data word, write ignored");
        run_frame(15'h4001, 1'b0, 16'hD800, 0, "R3 R5 negative sample, read ignored");
        run_frame(15'h3FFF, 1'b1, 16'h0000, 1, "R4 R11 over-range");
        run_frame(15'h3FFF, 1'b0, 16'h0000, 0, "R4 full scale without over-range");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule